// File: doc/BRIEF.md
# Programmable Asynchronous External Memory Controller

This block turns single-word requests from an internal master into timed cycles on an external asynchronous bus. A request carries a 32-bit address, a read/write flag and 32-bit write data, and uses a valid/ready handshake. The top two address bits must hold `10`. The next two bits then pick one of four chip-enable spaces. That is how address 0x9000_0000 reaches the second enable and 0xB000_0000 reaches the fourth.

Each space has its own 32-bit control word, written through a small configuration port. The word sets the device type and the lengths of the read and write setup, strobe and hold phases, counted in bus-clock cycles. Every access runs setup, then strobe, then hold. The controller holds the chip enable low through all three phases and pulses output enable or write enable only during the strobe phase. It then returns a one-cycle response. A space whose device type is not 32-bit asynchronous, or an address outside the four spaces, gets an immediate error response and no bus cycle.

A global control word sits beside the space words. It is stored and can be read back, and it does not affect the bus.

Top module: `amc_top`

## Requirements
- R1: An address whose bits [31:30] are `10` selects space `addr[29:28]`. During that access only `ceN[space]` is low, and `ceN` is all ones outside an access.
- R2: `cfgSel` value 0 addresses the global word and values 1 to 4 address the control words of spaces 0 to 3. A write with `cfgWrEn` high updates the word at the clock edge, and `cfgRdata` shows the selected word.
- R3: Control-word fields are laid out as follows:
  - write setup [31:28]
  - write strobe [27:22]
  - write hold low bits [21:20]
  - read setup [19:16]
  - turnaround [15:14]
  - read strobe [13:8]
  - device type [7:4]
  - write hold high bit [3]
  - read hold [2:0]

  A read runs read-setup cycles with the enable low and both strobes high, then read-strobe cycles with `oeN` low, then read-hold cycles with both strobes high.
- R4: A write follows the same three phases with the write fields. `weN` is low only in the strobe phase, `oeN` stays high, and `extDataOe` is high with `extDataOut` equal to the write data for the whole access.
- R5: The write hold count is the 3-bit value {bit 3, bits [21:20]}.
- R6: A timing field of zero gives a phase of one cycle.
- R7: Read data is sampled from `extDataIn` in the last strobe cycle. `rspValid` pulses for exactly one cycle, in the cycle after the last hold cycle, and `rspData` carries the sampled word.
- R8: Device type code 0010 is 32-bit asynchronous and is the only code served. If the request has another type code, or the address is outside the four spaces, `rspValid` and `rspErr` go high in the cycle after acceptance and no enable or strobe moves.
- R9: Turnaround is inserted when a write follows a non-error read to the same space. The write then waits the turnaround field's number of cycles, with all enables high, before its setup phase starts. A value of 0 inserts nothing. Error responses do not change the remembered previous access.
- R10: `extAddr` stays stable while a chip enable is low, and `oeN` and `weN` are never low together.
- R11: After reset:
  - all enables and strobes are high
  - `reqReady` is high
  - every space word reads 0x0000_0020, which is the asynchronous type with all timing fields at zero

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Request byte address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Completion was an error |
| rspData | output | 32 | Read data for the completed read |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration word select |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Selected configuration word |
| ceN | output | 4 | Active-low chip enables, one per space |
| oeN | output | 1 | Active-low output enable |
| weN | output | 1 | Active-low write enable |
| extAddr | output | 32 | External address |
| extDataOut | output | 32 | External write data |
| extDataOe | output | 1 | External data driver enable |
| extDataIn | input | 32 | External read data |

## Verification
The assertions watch the bus discipline on every cycle:
- at most one enable is low
- output enable is low only in a read, and write enable only in a write with data driven
- the address is stable through each access
- the response is a single-cycle pulse that never coincides with ready
- an error completes without any enable

The phase lengths, the zero-to-one rule, the joined write hold, the turnaround gap and the exact sampling cycle of read data depend on the programmed words. Only the bench's scenarios can show these. It counts cycles per phase against the fields and feeds a device model whose data changes every strobe cycle.

// File: rtl/amc_pkg.sv
package amc_pkg;

  localparam int PH_W = 6;
  localparam logic [3:0] TYPE_ASYNC32 = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD, ST_RESP
  } amcState_t;

  typedef struct packed {
    logic [3:0] wrSetup;
    logic [5:0] wrStrobe;
    logic [2:0] wrHold;
    logic [3:0] rdSetup;
    logic [1:0] turn;
    logic [5:0] rdStrobe;
    logic [3:0] devType;
    logic [2:0] rdHold;
  } spaceCfg_t;

  typedef struct packed {
    logic latchReq;
    logic capture;
  } amcStrobe_t;

  function automatic spaceCfg_t unpackCfg(input logic [31:0] w);
    spaceCfg_t c;
    c.wrSetup  = w[31:28];
    c.wrStrobe = w[27:22];
    c.wrHold   = {w[3], w[21:20]};
    c.rdSetup  = w[19:16];
    c.turn     = w[15:14];
    c.rdStrobe = w[13:8];
    c.devType  = w[7:4];
    c.rdHold   = w[2:0];
    return c;
  endfunction

  function automatic logic [PH_W-1:0] phaseLen(input logic [PH_W-1:0] v);
    return (v == '0) ? PH_W'(1) : v;
  endfunction

endpackage

// File: rtl/amc_datapath.sv
module amc_datapath
  import amc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_SPACES = 4,
  parameter logic [1:0] REGION_TAG = 2'b10,
  parameter logic [31:0] RESET_CTL = 32'h0000_0020,
  localparam int SPACE_W = $clog2(NUM_SPACES),
  localparam int SEL_W = $clog2(NUM_SPACES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [SEL_W-1:0]   cfgSel,
  input  logic [31:0]        cfgWdata,
  output logic [31:0]        cfgRdata,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               reqInRange,
  output logic [SPACE_W-1:0] reqSpace,
  output spaceCfg_t          reqCfg,
  input  amcStrobe_t         strb,
  output logic [ADDR_W-1:0]  extAddr,
  output logic [DATA_W-1:0]  extDataOut,
  input  logic [DATA_W-1:0]  extDataIn,
  output logic [DATA_W-1:0]  rspData
);

  logic [31:0] globalQ;
  logic [31:0] spaceQ [NUM_SPACES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) globalQ <= '0;
    else if (cfgWrEn && cfgSel == '0) globalQ <= cfgWdata;
  end

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) spaceQ[s] <= RESET_CTL;
      else if (cfgWrEn && cfgSel == SEL_W'(s + 1)) spaceQ[s] <= cfgWdata;
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (cfgSel == '0) cfgRdata = globalQ;
    else if (cfgSel <= SEL_W'(NUM_SPACES)) cfgRdata = spaceQ[SPACE_W'(cfgSel - 1'b1)];
  end

  always_comb begin
    reqInRange = (reqAddr[ADDR_W-1 -: 2] == REGION_TAG);
    reqSpace   = reqAddr[ADDR_W-3 -: SPACE_W];
    reqCfg     = unpackCfg(spaceQ[reqSpace]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extAddr    <= '0;
      extDataOut <= '0;
    end else if (strb.latchReq) begin
      extAddr    <= reqAddr;
      extDataOut <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspData <= '0;
    else if (strb.capture) rspData <= extDataIn;
  end

endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
  import amc_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  localparam int SPACE_W = $clog2(NUM_SPACES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic                  reqInRange,
  input  logic [SPACE_W-1:0]    reqSpace,
  input  spaceCfg_t             reqCfg,
  output logic                  reqReady,
  output amcStrobe_t            strb,
  output logic [NUM_SPACES-1:0] ceN,
  output logic                  oeN,
  output logic                  weN,
  output logic                  dataOe,
  output logic                  rspValid,
  output logic                  rspErr
);

  amcState_t state;
  logic [PH_W-1:0] cnt, setupLen, strobeLen, holdLen;
  logic [PH_W-1:0] nextSetup, nextStrobe, nextHold;
  logic curWrite, lastRead, errQ, accept, reqOk, needTurn, active;
  logic [SPACE_W-1:0] curSpace, lastSpace;

  always_comb begin
    accept     = reqValid && (state == ST_IDLE);
    reqOk      = reqInRange && (reqCfg.devType == TYPE_ASYNC32);
    needTurn   = reqWrite && lastRead && (lastSpace == reqSpace) && (reqCfg.turn != '0);
    nextSetup  = phaseLen(reqWrite ? {2'b00, reqCfg.wrSetup}  : {2'b00, reqCfg.rdSetup});
    nextStrobe = phaseLen(reqWrite ? reqCfg.wrStrobe          : reqCfg.rdStrobe);
    nextHold   = phaseLen(reqWrite ? {3'b000, reqCfg.wrHold}  : {3'b000, reqCfg.rdHold});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      setupLen  <= '0;
      strobeLen <= '0;
      holdLen   <= '0;
      curWrite  <= 1'b0;
      curSpace  <= '0;
      lastRead  <= 1'b0;
      lastSpace <= '0;
      errQ      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          if (!reqOk) begin
            errQ  <= 1'b1;
            state <= ST_RESP;
          end else begin
            errQ      <= 1'b0;
            curWrite  <= reqWrite;
            curSpace  <= reqSpace;
            setupLen  <= nextSetup;
            strobeLen <= nextStrobe;
            holdLen   <= nextHold;
            lastRead  <= !reqWrite;
            lastSpace <= reqSpace;
            if (needTurn) begin
              state <= ST_TURN;
              cnt   <= PH_W'(reqCfg.turn) - 1'b1;
            end else begin
              state <= ST_SETUP;
              cnt   <= nextSetup - 1'b1;
            end
          end
        end
        ST_TURN: if (cnt == '0) begin
          state <= ST_SETUP;
          cnt   <= setupLen - 1'b1;
        end else cnt <= cnt - 1'b1;
        ST_SETUP: if (cnt == '0) begin
          state <= ST_STROBE;
          cnt   <= strobeLen - 1'b1;
        end else cnt <= cnt - 1'b1;
        ST_STROBE: if (cnt == '0) begin
          state <= ST_HOLD;
          cnt   <= holdLen - 1'b1;
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt == '0) state <= ST_RESP;
                 else cnt <= cnt - 1'b1;
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    active        = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    reqReady      = (state == ST_IDLE);
    strb.latchReq = accept;
    strb.capture  = (state == ST_STROBE) && (cnt == '0) && !curWrite;
    ceN           = '1;
    if (active) ceN[curSpace] = 1'b0;
    oeN           = !((state == ST_STROBE) && !curWrite);
    weN           = !((state == ST_STROBE) && curWrite);
    dataOe        = active && curWrite;
    rspValid      = (state == ST_RESP);
    rspErr        = rspValid && errQ;
  end

endmodule

// File: rtl/amc_top.sv
module amc_top
  import amc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_SPACES = 4,
  parameter logic [31:0] RESET_CTL = 32'h0000_0020,
  localparam int SPACE_W = $clog2(NUM_SPACES),
  localparam int SEL_W = $clog2(NUM_SPACES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  rspValid,
  output logic                  rspErr,
  output logic [DATA_W-1:0]     rspData,
  input  logic                  cfgWrEn,
  input  logic [SEL_W-1:0]      cfgSel,
  input  logic [31:0]           cfgWdata,
  output logic [31:0]           cfgRdata,
  output logic [NUM_SPACES-1:0] ceN,
  output logic                  oeN,
  output logic                  weN,
  output logic [ADDR_W-1:0]     extAddr,
  output logic [DATA_W-1:0]     extDataOut,
  output logic                  extDataOe,
  input  logic [DATA_W-1:0]     extDataIn
);

  amcStrobe_t         strb;
  spaceCfg_t          reqCfg;
  logic               reqInRange;
  logic [SPACE_W-1:0] reqSpace;

  amc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SPACES(NUM_SPACES), .RESET_CTL(RESET_CTL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqInRange(reqInRange),
    .reqSpace(reqSpace), .reqCfg(reqCfg), .strb(strb), .extAddr(extAddr),
    .extDataOut(extDataOut), .extDataIn(extDataIn), .rspData(rspData)
  );

  amc_ctrl #(.NUM_SPACES(NUM_SPACES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqInRange(reqInRange), .reqSpace(reqSpace), .reqCfg(reqCfg), .reqReady(reqReady),
    .strb(strb), .ceN(ceN), .oeN(oeN), .weN(weN), .dataOe(extDataOe),
    .rspValid(rspValid), .rspErr(rspErr)
  );

endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
  parameter int ADDR_W = 32,
  parameter int NUM_SPACES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqReady,
  input logic                  rspValid,
  input logic                  rspErr,
  input logic [NUM_SPACES-1:0] ceN,
  input logic                  oeN,
  input logic                  weN,
  input logic [ADDR_W-1:0]     extAddr,
  input logic                  extDataOe
);

  // R1: never more than one space enabled
  p_ce_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~ceN) <= 1);

  // R4: output enable only in a read, never with data driven
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (weN && !extDataOe && ceN != '1));

  // R4: write enable only inside an access with data driven
  p_we_in_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (ceN != '1 && extDataOe));

  // R10: address held while an enable stays low
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ceN != '1 && $past(ceN) != '1) |-> $stable(extAddr));

  // R7: completion is a single-cycle pulse
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R7: no new request accepted in the completion cycle
  p_rsp_not_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R8: error completion follows a cycle with no enable low
  p_err_no_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> ($past(ceN) == '1 && ceN == '1));

endmodule

bind amc_top amc_checker #(.ADDR_W(ADDR_W), .NUM_SPACES(NUM_SPACES)) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid), .rspErr(rspErr),
  .ceN(ceN), .oeN(oeN), .weN(weN), .extAddr(extAddr), .extDataOe(extDataOe)
);

// File: tb/amc_top_tb_top.sv
module amc_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, cfgWrEn = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0, cfgWdata = '0;
  logic [2:0] cfgSel = '0;
  logic reqReady, rspValid, rspErr, oeN, weN, extDataOe;
  logic [31:0] rspData, cfgRdata, extAddr, extDataOut, extDataIn;
  logic [3:0] ceN;

  int checks = 0, fails = 0;
  logic [31:0] shadow [4];
  bit lastRd = 0;
  logic [1:0] lastSp = '0;
  logic [31:0] oeCnt = '0;

  always #5 clk = ~clk;

  amc_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspData(rspData), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .ceN(ceN), .oeN(oeN), .weN(weN), .extAddr(extAddr),
    .extDataOut(extDataOut), .extDataOe(extDataOe), .extDataIn(extDataIn)
  );

  // device model: data depends on address and on how long oeN has been low
  always @(posedge clk) oeCnt <= !oeN ? oeCnt + 1 : 32'd0;
  assign extDataIn = !oeN ? ((extAddr ^ 32'h5A5A_0F0F) + oeCnt) : 32'hDEAD_BEEF;

  task automatic chkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic cfgWrite(input int sel, input logic [31:0] w);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 3'(sel); cfgWdata = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
    chkEq("R2", "config readback", cfgRdata, w);
    if (sel > 0) shadow[sel-1] = w;
  endtask

  task automatic doAccess(input bit wr, input logic [1:0] sp, input logic [31:0] wd, input bit outRange);
    logic [31:0] addr, ctl, gotData;
    bit expErr, gotErr, done, badCe, badKind, badWd, badAddr, strobeNow;
    int expTurn, expSu, expSt, expHo, pre, su, st, ho;
    addr = {outRange ? 2'b01 : 2'b10, sp, 28'($urandom)};
    ctl = shadow[sp];
    expErr = outRange || (ctl[7:4] != 4'b0010);
    expTurn = (!expErr && wr && lastRd && lastSp == sp) ? int'(ctl[15:14]) : 0;
    expSu = lenOf(wr ? int'(ctl[31:28]) : int'(ctl[19:16]));
    expSt = lenOf(wr ? int'(ctl[27:22]) : int'(ctl[13:8]));
    expHo = lenOf(wr ? int'({ctl[3], ctl[21:20]}) : int'(ctl[2:0]));
    pre = 0; su = 0; st = 0; ho = 0; done = 0;
    badCe = 0; badKind = 0; badWd = 0; badAddr = 0; gotErr = 0; gotData = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(posedge clk);
    for (int k = 0; k < 400 && !done; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (rspValid) begin
        done = 1; gotErr = rspErr; gotData = rspData;
      end else if (ceN == 4'hF) pre++;
      else begin
        if (ceN != ~(4'b0001 << sp)) badCe = 1;
        if (extAddr != addr) badAddr = 1;
        if ((wr && !oeN) || (!wr && !weN)) badKind = 1;
        if (wr && (!extDataOe || extDataOut != wd)) badWd = 1;
        strobeNow = wr ? !weN : !oeN;
        if (strobeNow) st++;
        else if (st == 0) su++;
        else ho++;
      end
    end
    chkEq("R7", "completion seen", 32'(done), 32'd1);
    chkEq("R8", "error flag", 32'(gotErr), 32'(expErr));
    if (expErr) begin
      chkEq("R8", "bus cycles on error", 32'(pre + su + st + ho), 32'd0);
    end else begin
      chkEq("R1", "enable select", 32'(badCe), 32'd0);
      chkEq("R10", "address", 32'(badAddr), 32'd0);
      chkEq("R9", "turnaround gap", 32'(pre), 32'(expTurn));
      chkEq(wr ? "R4" : "R3", "setup cycles", 32'(su), 32'(expSu));
      chkEq(wr ? "R4" : "R3", "strobe cycles", 32'(st), 32'(expSt));
      chkEq(wr ? "R5" : "R3", "hold cycles", 32'(ho), 32'(expHo));
      chkEq("R4", "strobe kind", 32'(badKind), 32'd0);
      if (wr) chkEq("R4", "write data", 32'(badWd), 32'd0);
      else chkEq("R7", "read data", gotData, (addr ^ 32'h5A5A_0F0F) + 32'(expSt - 1));
      lastRd = !wr; lastSp = sp;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) shadow[i] = 32'h0000_0020;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chkEq("R11", "ceN", 32'(ceN), 32'hF);
    chkEq("R11", "strobes", 32'({oeN, weN}), 32'h3);
    chkEq("R11", "ready", 32'(reqReady), 32'd1);
    for (int s = 1; s <= 4; s++) begin
      cfgSel = 3'(s); #1;
      chkEq("R11", "space word", cfgRdata, 32'h0000_0020);
    end
    cfgWrite(0, 32'h0000_3300);
    // R6: all fields zero give one-cycle phases
    doAccess(0, 2'd1, 32'h0, 0);
    doAccess(1, 2'd3, 32'h1234_5678, 0);
    // R3: long read setup, strobe and hold
    cfgWrite(4, 32'hFFFF_FF23);
    doAccess(0, 2'd3, 32'h0, 0);
    // R5: write hold {1,01} = 5 cycles; turnaround 3 after the read above
    cfgWrite(4, 32'h2111_C22A);
    doAccess(0, 2'd3, 32'h0, 0);
    doAccess(1, 2'd3, 32'hCAFE_F00D, 0);
    // R9: read in another space then write: no gap
    doAccess(0, 2'd0, 32'h0, 0);
    doAccess(1, 2'd3, 32'hA5A5_A5A5, 0);
    // R8: non-async type and out-of-range address
    cfgWrite(3, 32'h1111_1130);
    doAccess(0, 2'd2, 32'h0, 0);
    doAccess(1, 2'd1, 32'h0, 1);
    // R2: global word readback
    cfgSel = 3'd0; #1;
    chkEq("R2", "global word", cfgRdata, 32'h0000_3300);
    // constrained random mix
    for (int n = 0; n < 160; n++) begin
      if (n % 12 == 0) begin
        w = $urandom;
        w[7:4] = ($urandom % 5 == 0) ? 4'($urandom) : 4'b0010;
        cfgWrite(1 + int'($urandom % 4), w);
      end
      doAccess(1'($urandom), 2'($urandom), $urandom, ($urandom % 16) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule